// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. It watches a shared, free-running 64-bit main counter that is supplied from outside. When the counter reaches the programmed comparator value, it raises an edge interrupt. The comparison is done as a signed difference, so a target that the counter has already passed counts as due.

The channel can run in one-shot or periodic mode, and it can compare on the full 64 bits or on the low 32 bits only. In periodic mode each match moves the comparator forward by a stored period. A one-shot channel in 32-bit mode also fires when the low 32 bits of the counter wrap.

Software reaches the channel through 32-bit register writes and reads. A 2-bit selector picks the configuration word or one half of the comparator. The channel drives three outputs:
- a one-cycle interrupt pulse,
- a one-cycle request to set the channel's bit in a shared interrupt-status register,
- the routing number that software programmed.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the configuration word and the 64-bit comparator read as zero, and `irq_pulse`, `sts_set` and `route` are low.
- R2: Configuration bits are placed as follows: bit 1 = level type, bit 2 = interrupt enable, bit 3 = periodic, bit 6 = set-value, bit 8 = 32-bit mode, bits 13:9 = route, bit 14 = spare. Bits in mask 0xFFFF80B1 are read-only zero and writes to them have no effect. The upper configuration word (select 1) reads zero and ignores writes. `route` shows bits 13:9.
- R3: In 64-bit mode the channel is due when the signed value of (comparator − counter), taken on 64 bits, is zero or negative.
- R4: In 32-bit mode the same signed test is made on the low 32 bits of the comparator and the counter only.
- R5: `sts_set` pulses for one cycle, on the clock edge that ends the first enabled cycle in which the channel is due. It stays low while the due condition persists.
- R6: `irq_pulse` equals that `sts_set` pulse gated by the interrupt-enable bit. `sts_set` does not depend on that bit.
- R7: When `glb_en` is low, neither output fires, even if the channel is due.
- R8: In periodic mode with a nonzero period, the comparator becomes comparator + period on the edge of each firing.
- R9: In 32-bit periodic mode the reloaded sum is cut to 32 bits, and the comparator's upper half becomes zero.
- R10: A one-shot channel in 32-bit mode also fires when the low 32 bits of the counter fall below their value in the previous enabled cycle (a wrap). A periodic channel does not fire on a wrap.
- R11: A write with select 2 updates only comparator bits 31:0, and select 3 updates only bits 63:32. Reads with select 0/1/2/3 return cfg-low/cfg-high/cmp-low/cmp-high on the cycle after `rd_en`.
- R12: If the set-value bit is clear, a comparator write loads the same half of both the comparator and the period. If it is set, the write loads only the comparator. Any comparator write clears the set-value bit.
- R13: In 32-bit mode a value written with select 2 is masked to its low 31 bits.
- R14: Setting the level-type bit changes nothing: the channel still produces one-cycle edge pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_cnt | input | 64 | Shared main counter value |
| glb_en | input | 1 | Global enable for counting and interrupts |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 cfg low, 1 cfg high, 2 cmp low, 3 cmp high |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read select, same encoding as `wr_sel` |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_pulse | output | 1 | One-cycle edge interrupt |
| sts_set | output | 1 | One-cycle request to set this channel's status bit |
| route | output | 5 | Programmed routing number |

## Verification
Most internal faults in this channel show up at the ports one cycle after the stimulus that exposes them:
- **Wrong due condition or wrong edge tracking.** The `sts_set` pulse appears in the wrong cycle, is missing, or repeats.
- **Corrupted comparator or period.** The fault may stay hidden until the next periodic firing. It then shows as a wrong reloaded comparator value on the next read, or as a firing at the wrong counter value.

A stale set-value bit or a bad write mask is visible on the very next read of the configuration word.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int HALF_W = 32;
  localparam int FULL_W = 64;
  localparam int ROUTE_W = 5;

  localparam int B_LEVEL  = 1;
  localparam int B_IEN    = 2;
  localparam int B_PERIOD = 3;
  localparam int B_SETVAL = 6;
  localparam int B_M32    = 8;
  localparam int B_ROUTE  = 9;

  localparam logic [HALF_W-1:0] CFG_WR_MASK = 32'h0000_7F4E;
  localparam logic [HALF_W-1:0] LO31_MASK   = 32'h7FFF_FFFF;

  typedef enum logic [1:0] {
    SEL_CFG_LO = 2'd0,
    SEL_CFG_HI = 2'd1,
    SEL_CMP_LO = 2'd2,
    SEL_CMP_HI = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_pkg::*;
#(
  parameter int DW = HALF_W,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          fire,
  output logic [DW-1:0] cfg_q,
  output logic [CW-1:0] cmp_q,
  output logic [CW-1:0] period_q
);
  logic m32, periodic, setval;
  logic cmp_wr_lo, cmp_wr_hi, cmp_wr, cfg_wr;
  logic [DW-1:0] lo_val;
  logic [CW-1:0] sum;
  logic per_nz, reload;

  assign m32      = cfg_q[B_M32];
  assign periodic = cfg_q[B_PERIOD];
  assign setval   = cfg_q[B_SETVAL];

  assign cfg_wr    = wr_en && (wr_sel == SEL_CFG_LO);
  assign cmp_wr_lo = wr_en && (wr_sel == SEL_CMP_LO);
  assign cmp_wr_hi = wr_en && (wr_sel == SEL_CMP_HI);
  assign cmp_wr    = cmp_wr_lo || cmp_wr_hi;

  assign lo_val = m32 ? (wr_data & LO31_MASK) : wr_data;
  assign sum    = cmp_q + period_q;
  assign per_nz = m32 ? (period_q[DW-1:0] != '0) : (period_q != '0);
  assign reload = fire && periodic && per_nz && !cmp_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cmp_q    <= '0;
      period_q <= '0;
    end else begin
      if (cfg_wr) begin
        cfg_q <= wr_data & CFG_WR_MASK;
      end else if (cmp_wr) begin
        cfg_q[B_SETVAL] <= 1'b0;
      end
      if (cmp_wr_lo) begin
        cmp_q[DW-1:0] <= lo_val;
        if (!setval) period_q[DW-1:0] <= lo_val;
      end else if (cmp_wr_hi) begin
        cmp_q[CW-1:DW] <= wr_data;
        if (!setval) period_q[CW-1:DW] <= wr_data;
      end else if (reload) begin
        if (m32) cmp_q <= {{DW{1'b0}}, sum[DW-1:0]};
        else     cmp_q <= sum;
      end
    end
  end

  // R12
  setval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !cfg_q[B_SETVAL]);
  // R13
  mask31_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_lo && m32) |=> !cmp_q[DW-1]);
  // R11
  hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_hi |=> (cmp_q[DW-1:0] == $past(cmp_q[DW-1:0])));
  // R8
  reload_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !m32) |=> (cmp_q == $past(cmp_q) + $past(period_q)));
  // R9
  trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && m32) |=> (cmp_q[CW-1:DW] == '0));
endmodule

// File: rtl/evt_match.sv
module evt_match
  import evt_pkg::*;
#(
  parameter int CW = FULL_W,
  localparam int DW = CW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en,
  input  logic [CW-1:0] main_cnt,
  input  logic [CW-1:0] cmp,
  input  logic          m32,
  input  logic          periodic,
  input  logic          ien,
  output logic          fire,
  output logic          irq_pulse,
  output logic          sts_set
);
  logic signed [CW-1:0] diff_w;
  logic signed [DW-1:0] diff_n;
  logic due, due_q, en_q, wrap;
  logic [DW-1:0] prev_lo;

  assign diff_w = $signed(cmp - main_cnt);
  assign diff_n = $signed(cmp[DW-1:0] - main_cnt[DW-1:0]);
  assign due    = m32 ? (diff_n <= 0) : (diff_w <= 0);
  assign wrap   = m32 && !periodic && en_q && (main_cnt[DW-1:0] < prev_lo);
  assign fire   = glb_en && ((due && !due_q) || wrap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      due_q     <= 1'b0;
      en_q      <= 1'b0;
      prev_lo   <= '0;
      irq_pulse <= 1'b0;
      sts_set   <= 1'b0;
    end else begin
      due_q     <= due && glb_en;
      en_q      <= glb_en;
      prev_lo   <= main_cnt[DW-1:0];
      sts_set   <= fire;
      irq_pulse <= fire && ien;
    end
  end

  // R6
  irq_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> sts_set);
  // R6
  irq_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien && !fire |=> !irq_pulse);
  // R7
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !sts_set);
endmodule

// File: rtl/evt_rd_port.sv
module evt_rd_port
  import evt_pkg::*;
#(
  parameter int DW = HALF_W,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  input  logic [DW-1:0] cfg,
  input  logic [CW-1:0] cmp,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mux;

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_CFG_LO: mux = cfg;
      SEL_CFG_HI: mux = '0;
      SEL_CMP_LO: mux = cmp[DW-1:0];
      SEL_CMP_HI: mux = cmp[CW-1:DW];
      default:    mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mux;
  end
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_pkg::*;
#(
  parameter int DW = HALF_W,
  parameter int RW = ROUTE_W,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] main_cnt,
  input  logic          glb_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          irq_pulse,
  output logic          sts_set,
  output logic [RW-1:0] route
);
  logic [DW-1:0] cfg;
  logic [CW-1:0] cmp, period;
  logic fire;

  evt_cfg_regs #(.DW(DW)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .fire(fire), .cfg_q(cfg), .cmp_q(cmp),
    .period_q(period)
  );

  evt_match #(.CW(CW)) i_match (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .main_cnt(main_cnt),
    .cmp(cmp), .m32(cfg[B_M32]), .periodic(cfg[B_PERIOD]),
    .ien(cfg[B_IEN]), .fire(fire), .irq_pulse(irq_pulse),
    .sts_set(sts_set)
  );

  evt_rd_port #(.DW(DW)) i_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
    .cfg(cfg), .cmp(cmp), .rd_data(rd_data)
  );

  assign route = cfg[B_ROUTE +: RW];

  // R2
  cfg_hi_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_CFG_HI) |=> (rd_data == '0));
endmodule

// File: tb/test_evt_cmp_channel.sv
module test_evt_cmp_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] main_cnt = '0;
  logic glb_en = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [1:0] rd_sel = '0;
  logic [31:0] rd_data;
  logic irq_pulse, sts_set;
  logic [4:0] route;
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  evt_cmp_channel i_evt_cmp_channel (
    .clk(clk), .rst_n(rst_n), .main_cnt(main_cnt), .glb_en(glb_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_pulse(irq_pulse),
    .sts_set(sts_set), .route(route)
  );

  localparam logic [31:0] C_IEN = 32'h4, C_LVL = 32'h2, C_PER = 32'h8,
                          C_SV = 32'h40, C_M32 = 32'h100;

  // {m32, expected irq, cmp, cnt}
  localparam logic [129:0] VEC [8] = '{
    {1'b0, 1'b0, 64'd100, 64'd99},
    {1'b0, 1'b1, 64'd100, 64'd100},
    {1'b0, 1'b1, 64'd100, 64'd500},
    {1'b0, 1'b0, 64'h1_0000_0000, 64'h0_FFFF_FFFF},
    {1'b0, 1'b0, 64'd5, 64'hFFFF_FFFF_FFFF_FFF0},
    {1'b1, 1'b1, 64'h1_0000_0010, 64'h20},
    {1'b1, 1'b0, 64'h10, 64'h1_0000_0000},
    {1'b0, 1'b1, 64'h10, 64'h1_0000_0000}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    rd_en = 1'b1; rd_sel = s;
    step();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic arm(input logic [31:0] cfg, input logic [63:0] cmpv);
    glb_en = 1'b0;
    wr(2'd0, cfg);
    wr(2'd3, cmpv[63:32]);
    wr(2'd2, cmpv[31:0]);
    step();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 irq", irq_pulse, 0);
    chk("R1 sts", sts_set, 0);
    chk("R1 route", route, 0);
    rd(2'd0, rv); chk("R1 cfg", rv, 0);
    rd(2'd2, rv); chk("R1 cmp lo", rv, 0);
    rd(2'd3, rv); chk("R1 cmp hi", rv, 0);

    // R3 R4 vector table
    for (int i = 0; i < 8; i++) begin
      arm(C_IEN | (VEC[i][129] ? C_M32 : 32'h0), VEC[i][127:64]);
      main_cnt = VEC[i][63:0];
      glb_en = 1'b1;
      step();
      chk(VEC[i][129] ? "R4 vec" : "R3 vec", irq_pulse, {63'd0, VEC[i][128]});
      glb_en = 1'b0;
    end

    // R2 write mask and route
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, rv); chk("R2 mask", rv, 32'h0000_7F4E);
    chk("R2 route", route, 5'h1F);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, rv); chk("R2 cfg hi", rv, 0);

    // R5 R14 one-cycle pulse with level type set
    arm(C_IEN | C_LVL, 64'd50);
    main_cnt = 64'd60; glb_en = 1'b1;
    step(); chk("R14 pulse", irq_pulse, 1);
    step(); chk("R5 single", irq_pulse, 0);
    chk("R5 sts single", sts_set, 0);

    // R6 interrupt enable off
    arm(32'h0, 64'd50);
    glb_en = 1'b1;
    step(); chk("R6 sts", sts_set, 1); chk("R6 irq", irq_pulse, 0);

    // R7 global enable off
    arm(C_IEN, 64'd50);
    step(); chk("R7 sts", sts_set, 0); chk("R7 irq", irq_pulse, 0);

    // R8 periodic reload, R12 set-value
    arm(C_IEN | C_PER, 64'd100);
    main_cnt = 64'd100; glb_en = 1'b1;
    step(); chk("R8 fire", irq_pulse, 1);
    rd(2'd2, rv); chk("R8 reload", rv, 200);
    wr(2'd0, C_IEN | C_PER | C_SV);
    wr(2'd2, 32'd1000);
    rd(2'd0, rv); chk("R12 clear", rv[6], 0);
    rd(2'd2, rv); chk("R12 cmp", rv, 1000);
    main_cnt = 64'd1000;
    step(); chk("R12 fire", irq_pulse, 1);
    rd(2'd2, rv); chk("R12 period kept", rv, 1100);

    // R9 32-bit truncation
    arm(C_IEN | C_PER | C_M32, {32'd5, 32'h7FFF_FFF0});
    main_cnt = 64'h7FFF_FFF0; glb_en = 1'b1;
    step(); chk("R9 fire", irq_pulse, 1);
    rd(2'd2, rv); chk("R9 lo", rv, 32'hFFFF_FFE0);
    rd(2'd3, rv); chk("R9 hi", rv, 0);

    // R13 31-bit mask
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, rv); chk("R13 mask", rv, 32'h7FFF_FFFF);

    // R11 halves
    arm(32'h0, 64'h0000_1111_0000_2222);
    wr(2'd3, 32'hABCD);
    rd(2'd2, rv); chk("R11 lo kept", rv, 32'h2222);
    rd(2'd3, rv); chk("R11 hi", rv, 32'hABCD);

    // R10 wrap in one-shot 32-bit
    arm(C_IEN | C_M32, 64'h10);
    main_cnt = 64'h0_FFFF_FFF0; glb_en = 1'b1;
    step(); chk("R10 before", irq_pulse, 0);
    main_cnt = 64'h1_0000_0002;
    step(); chk("R10 wrap", irq_pulse, 1);
    arm(C_IEN | C_M32 | C_PER, 64'h10);
    main_cnt = 64'h0_FFFF_FFF0; glb_en = 1'b1;
    step();
    main_cnt = 64'h1_0000_0002;
    step(); chk("R10 periodic no wrap", irq_pulse, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule